// File: doc/BRIEF.md
# Multi-class oldest-first issue selector

The selector sits between five per-class ready queues and the execution pipeline. The classes are integer, floating point, branch, memory and miscellaneous. Each queue shows a small window of its leading entries to the selector, entry 0 being the head. Each entry carries a valid bit, a 16-bit sequence number and a squashed flag. In one cycle the selector runs a fixed chain of selection passes. A pass either drops a squashed head or picks the oldest eligible head and writes it into the next free slot of the issue bundle.

Integer, floating point, branch and memory instructions are each held to a per-class issue cap. Miscellaneous instructions are bounded only by the total bundle width. For every class, the selector reports in the same cycle how many entries the queue must pop, covering both issued and discarded entries. The bundle and the per-class issue statistics are registered and appear one clock later.

Top module: `issue_select`

## Requirements
- R1: At most WIDTH (default 4) instructions are issued per cycle. size_o equals the number of valid bundle slots, and valid slots fill from slot 0 upward with no gaps.
- R2: Per cycle, the class codes 0 (integer), 1 (floating point), 2 (branch) and 3 (memory) issue at most CAP_INT=2, CAP_FP=2, CAP_BR=1 and CAP_MEM=2 instructions respectively. A class that has reached its cap is not examined again in that cycle.
- R3: Class code 4 (miscellaneous) has no cap of its own and can fill the whole bundle.
- R4: Each pass issues the eligible, non-squashed head with the smallest sequence number. Slot k holds the k-th issue of the cycle. The value 16'hFFFF is reserved and never presented.
- R5: On equal sequence numbers the lower class code wins. A higher class is chosen only when its sequence number is strictly smaller.
- R6: If any eligible head is squashed, the squashed head of the lowest class code is popped in that pass. No slot is filled and no cap or width is consumed.
- R7: A cycle performs at most PASSES (default 8) pop actions, issues and discards together. Further pops wait for later cycles. Discards stop once the bundle is full.
- R8: pop_o[c] gives, combinationally in the same cycle, the number of entries taken from window c (issued plus discarded). The bundle built from those entries appears on the outputs after the next rising clock edge.
- R9: stat_o[c] accumulates the number of class-c instructions issued and is updated on the same edge as the bundle.
- R10: While rst_ni is low, all slots are invalid, size_o is 0 and every statistic is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| win_v_i | input | 5x4 | Valid bit per class per window entry (entry 0 = head) |
| win_sq_i | input | 5x4 | Squashed flag per class per window entry |
| win_seq_i | input | 5x4x16 | Sequence number per class per window entry |
| pop_o | output | 5x3 | Entries to pop per class this cycle |
| slot_v_o | output | 4 | Bundle slot valid |
| slot_cls_o | output | 4x3 | Class code per bundle slot |
| slot_seq_o | output | 4x16 | Sequence number per bundle slot |
| size_o | output | 3 | Number of valid bundle slots |
| stat_o | output | 5x32 | Accumulated issue count per class |

## Verification
The assertions check, on every cycle, the structural limits of the bundle: the width bound, gap-free slot filling, each class cap, and the pass budget on the pop counts. They also check that every issued class was actually popped one cycle earlier and that each statistic grows by exactly the number of its class in the bundle. Oldest-first choice, the tie order between classes, the discard priority of squashed heads and the carry-over of work beyond the pass budget depend on the window contents. Only the bench's reference model shows these, by predicting pops, slots and statistics each cycle for directed and random window patterns.

// File: rtl/issue_pkg.sv
package issue_pkg;
  localparam int NCLS = 5;
  localparam int CLS_W = 3;
  typedef enum logic [CLS_W-1:0] {
    CLS_INT  = 3'd0,
    CLS_FP   = 3'd1,
    CLS_BR   = 3'd2,
    CLS_MEM  = 3'd3,
    CLS_MISC = 3'd4
  } cls_e;
endpackage

// File: rtl/issue_pass.sv
// One selection step: discard a squashed head or issue the oldest head.
module issue_pass import issue_pkg::*; #(
  parameter int SW      = 16,
  parameter int LOOK    = 4,
  parameter int WIDTH   = 4,
  parameter int CAP_INT = 2,
  parameter int CAP_FP  = 2,
  parameter int CAP_BR  = 1,
  parameter int CAP_MEM = 2,
  parameter int IW      = 3,
  parameter int CW      = 3
) (
  input  logic [NCLS-1:0][LOOK-1:0]         win_v_i,
  input  logic [NCLS-1:0][LOOK-1:0]         win_sq_i,
  input  logic [NCLS-1:0][LOOK-1:0][SW-1:0] win_seq_i,
  input  logic [NCLS-1:0][IW-1:0]           idx_i,
  input  logic [NCLS-1:0][CW-1:0]           cnt_i,
  input  logic [CW-1:0]                     tot_i,
  output logic [NCLS-1:0][IW-1:0]           idx_o,
  output logic [NCLS-1:0][CW-1:0]           cnt_o,
  output logic [CW-1:0]                     tot_o,
  output logic                              iss_v_o,
  output logic [CLS_W-1:0]                  iss_cls_o,
  output logic [SW-1:0]                     iss_seq_o
);
  logic [NCLS-1:0]         hv, hsq, elig, capped;
  logic [NCLS-1:0][SW-1:0] hseq;
  logic [NCLS-2:0][CW-1:0] cap;
  logic                    sq_found, found;
  logic [CLS_W-1:0]        sq_c, pk_c;
  logic [SW-1:0]           best;

  assign cap[0] = CW'(CAP_INT);
  assign cap[1] = CW'(CAP_FP);
  assign cap[2] = CW'(CAP_BR);
  assign cap[3] = CW'(CAP_MEM);

  for (genvar c = 0; c < NCLS; c++) begin : g_cap
    if (c == NCLS - 1) begin : g_free
      assign capped[c] = 1'b0;
    end else begin : g_lim
      assign capped[c] = cnt_i[c] >= cap[c];
    end
  end

  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      hv[c]   = 1'b0;
      hsq[c]  = 1'b0;
      hseq[c] = '1;
      for (int j = 0; j < LOOK; j++) begin
        if (idx_i[c] == IW'(j)) begin
          hv[c]   = win_v_i[c][j];
          hsq[c]  = win_sq_i[c][j];
          hseq[c] = win_seq_i[c][j];
        end
      end
      elig[c] = hv[c] && !capped[c] && (tot_i < CW'(WIDTH));
    end
  end

  always_comb begin
    sq_found = 1'b0;
    sq_c     = '0;
    found    = 1'b0;
    pk_c     = '0;
    best     = '1;
    for (int c = 0; c < NCLS; c++) begin
      if (!sq_found && elig[c] && hsq[c]) begin
        sq_found = 1'b1;
        sq_c     = CLS_W'(c);
      end
    end
    // strict compare keeps the lower class on a tie
    for (int c = 0; c < NCLS; c++) begin
      if (elig[c] && (!found || hseq[c] < best)) begin
        found = 1'b1;
        pk_c  = CLS_W'(c);
        best  = hseq[c];
      end
    end
  end

  always_comb begin
    idx_o     = idx_i;
    cnt_o     = cnt_i;
    tot_o     = tot_i;
    iss_v_o   = 1'b0;
    iss_cls_o = pk_c;
    iss_seq_o = best;
    if (sq_found) begin
      idx_o[sq_c] = idx_i[sq_c] + 1'b1;
    end else if (found) begin
      idx_o[pk_c] = idx_i[pk_c] + 1'b1;
      cnt_o[pk_c] = cnt_i[pk_c] + 1'b1;
      tot_o       = tot_i + 1'b1;
      iss_v_o     = 1'b1;
    end
  end
endmodule

// File: rtl/issue_stats.sv
module issue_stats #(
  parameter int NC     = 5,
  parameter int CW     = 3,
  parameter int STAT_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NC-1:0][CW-1:0]     cnt_i,
  output logic [NC-1:0][STAT_W-1:0] stat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= '0;
    end else begin
      for (int c = 0; c < NC; c++) stat_o[c] <= stat_o[c] + STAT_W'(cnt_i[c]);
    end
  end
endmodule

// File: rtl/issue_select.sv
module issue_select import issue_pkg::*; #(
  parameter int SW      = 16,
  parameter int LOOK    = 4,
  parameter int WIDTH   = 4,
  parameter int PASSES  = 8,
  parameter int CAP_INT = 2,
  parameter int CAP_FP  = 2,
  parameter int CAP_BR  = 1,
  parameter int CAP_MEM = 2,
  parameter int STAT_W  = 32,
  localparam int IW     = $clog2(LOOK + 1),
  localparam int CW     = $clog2(WIDTH + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NCLS-1:0][LOOK-1:0]         win_v_i,
  input  logic [NCLS-1:0][LOOK-1:0]         win_sq_i,
  input  logic [NCLS-1:0][LOOK-1:0][SW-1:0] win_seq_i,
  output logic [NCLS-1:0][IW-1:0]           pop_o,
  output logic [WIDTH-1:0]                  slot_v_o,
  output logic [WIDTH-1:0][CLS_W-1:0]       slot_cls_o,
  output logic [WIDTH-1:0][SW-1:0]          slot_seq_o,
  output logic [CW-1:0]                     size_o,
  output logic [NCLS-1:0][STAT_W-1:0]       stat_o
);
  logic [PASSES:0][NCLS-1:0][IW-1:0]  idx_c;
  logic [PASSES:0][NCLS-1:0][CW-1:0]  cnt_c;
  logic [PASSES:0][CW-1:0]            tot_c;
  logic [PASSES-1:0]                  iss_v;
  logic [PASSES-1:0][CLS_W-1:0]       iss_cls;
  logic [PASSES-1:0][SW-1:0]          iss_seq;

  logic [WIDTH-1:0]                   nxt_v;
  logic [WIDTH-1:0][CLS_W-1:0]        nxt_cls;
  logic [WIDTH-1:0][SW-1:0]           nxt_seq;

  assign idx_c[0] = '0;
  assign cnt_c[0] = '0;
  assign tot_c[0] = '0;

  for (genvar k = 0; k < PASSES; k++) begin : g_pass
    issue_pass #(
      .SW(SW), .LOOK(LOOK), .WIDTH(WIDTH),
      .CAP_INT(CAP_INT), .CAP_FP(CAP_FP), .CAP_BR(CAP_BR), .CAP_MEM(CAP_MEM),
      .IW(IW), .CW(CW)
    ) u_pass (
      .win_v_i  (win_v_i),
      .win_sq_i (win_sq_i),
      .win_seq_i(win_seq_i),
      .idx_i    (idx_c[k]),
      .cnt_i    (cnt_c[k]),
      .tot_i    (tot_c[k]),
      .idx_o    (idx_c[k+1]),
      .cnt_o    (cnt_c[k+1]),
      .tot_o    (tot_c[k+1]),
      .iss_v_o  (iss_v[k]),
      .iss_cls_o(iss_cls[k]),
      .iss_seq_o(iss_seq[k])
    );
  end

  assign pop_o = idx_c[PASSES];

  // slot index of an issuing pass is the running total before it
  always_comb begin
    nxt_v   = '0;
    nxt_cls = '0;
    nxt_seq = '0;
    for (int k = 0; k < PASSES; k++) begin
      for (int s = 0; s < WIDTH; s++) begin
        if (iss_v[k] && tot_c[k] == CW'(s)) begin
          nxt_v[s]   = 1'b1;
          nxt_cls[s] = iss_cls[k];
          nxt_seq[s] = iss_seq[k];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_v_o   <= '0;
      slot_cls_o <= '0;
      slot_seq_o <= '0;
      size_o     <= '0;
    end else begin
      slot_v_o   <= nxt_v;
      slot_cls_o <= nxt_cls;
      slot_seq_o <= nxt_seq;
      size_o     <= tot_c[PASSES];
    end
  end

  issue_stats #(.NC(NCLS), .CW(CW), .STAT_W(STAT_W)) u_stats (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_i (cnt_c[PASSES]),
    .stat_o(stat_o)
  );
endmodule

// File: rtl/issue_select_chk.sv
module issue_select_chk import issue_pkg::*; #(
  parameter int SW      = 16,
  parameter int LOOK    = 4,
  parameter int WIDTH   = 4,
  parameter int PASSES  = 8,
  parameter int CAP_INT = 2,
  parameter int CAP_FP  = 2,
  parameter int CAP_BR  = 1,
  parameter int CAP_MEM = 2,
  parameter int STAT_W  = 32,
  localparam int IW     = $clog2(LOOK + 1),
  localparam int CW     = $clog2(WIDTH + 1)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NCLS-1:0][IW-1:0]     pop_o,
  input logic [WIDTH-1:0]            slot_v_o,
  input logic [WIDTH-1:0][CLS_W-1:0] slot_cls_o,
  input logic [CW-1:0]               size_o,
  input logic [NCLS-1:0][STAT_W-1:0] stat_o
);
  int ncls [NCLS];
  int pops;

  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      ncls[c] = 0;
      for (int s = 0; s < WIDTH; s++)
        if (slot_v_o[s] && slot_cls_o[s] == CLS_W'(c)) ncls[c] = ncls[c] + 1;
    end
    pops = 0;
    for (int c = 0; c < NCLS; c++) pops = pops + int'(pop_o[c]);
  end

  p_size_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(size_o) <= WIDTH && $countones(slot_v_o) == int'(size_o));

  for (genvar s = 1; s < WIDTH; s++) begin : g_fill
    p_slot_fill_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_v_o[s] |-> slot_v_o[s-1]);
  end

  p_cap_int_r2: assert property (@(posedge clk_i) disable iff (!rst_ni) ncls[0] <= CAP_INT);
  p_cap_fp_r2:  assert property (@(posedge clk_i) disable iff (!rst_ni) ncls[1] <= CAP_FP);
  p_cap_br_r2:  assert property (@(posedge clk_i) disable iff (!rst_ni) ncls[2] <= CAP_BR);
  p_cap_mem_r2: assert property (@(posedge clk_i) disable iff (!rst_ni) ncls[3] <= CAP_MEM);

  p_pass_budget_r7: assert property (@(posedge clk_i) disable iff (!rst_ni) pops <= PASSES);

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    p_issue_popped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> ncls[c] <= int'($past(pop_o[c])));
    p_stat_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> stat_o[c] == $past(stat_o[c]) + STAT_W'(ncls[c]));
  end
endmodule

bind issue_select issue_select_chk #(
  .SW(SW), .LOOK(LOOK), .WIDTH(WIDTH), .PASSES(PASSES),
  .CAP_INT(CAP_INT), .CAP_FP(CAP_FP), .CAP_BR(CAP_BR), .CAP_MEM(CAP_MEM),
  .STAT_W(STAT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pop_o(pop_o), .slot_v_o(slot_v_o),
  .slot_cls_o(slot_cls_o), .size_o(size_o), .stat_o(stat_o)
);

// File: tb/tb_issue_select.sv
`timescale 1ns/1ps
module tb_issue_select;
  localparam int NC = 5, LOOK = 4, WIDTH = 4, PASSES = 8, SW = 16;
  localparam int CAPS [NC] = '{2, 2, 1, 2, 1000};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0][LOOK-1:0]         win_v, win_sq;
  logic [NC-1:0][LOOK-1:0][SW-1:0] win_seq;
  logic [NC-1:0][2:0]              pop;
  logic [WIDTH-1:0]                slot_v;
  logic [WIDTH-1:0][2:0]           slot_cls;
  logic [WIDTH-1:0][SW-1:0]        slot_seq;
  logic [2:0]                      size;
  logic [NC-1:0][31:0]             stat;

  issue_select dut (
    .clk_i(clk), .rst_ni(rst_n), .win_v_i(win_v), .win_sq_i(win_sq), .win_seq_i(win_seq),
    .pop_o(pop), .slot_v_o(slot_v), .slot_cls_o(slot_cls), .slot_seq_o(slot_seq),
    .size_o(size), .stat_o(stat)
  );

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  string tag = "R10";
  logic [SW-1:0] qs [NC][$];
  bit            qq [NC][$];
  int seqctr = 100;

  int e_pop [NC];
  int e_sz;
  int e_cls [WIDTH];
  int e_seq [WIDTH];
  longint e_stat [NC];
  bit have_exp = 0;

  task automatic chk(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic push(int c, int s, bit sq);
    qs[c].push_back(SW'(s));
    qq[c].push_back(sq);
  endtask

  task automatic drive();
    for (int c = 0; c < NC; c++)
      for (int j = 0; j < LOOK; j++) begin
        win_v[c][j]   = j < qs[c].size();
        win_sq[c][j]  = j < qs[c].size() ? qq[c][j] : 1'b0;
        win_seq[c][j] = j < qs[c].size() ? qs[c][j] : '1;
      end
  endtask

  // behavioural reference for one cycle
  task automatic model();
    int used [NC];
    int took [NC];
    int tot;
    tot = 0;
    for (int c = 0; c < NC; c++) begin used[c] = 0; took[c] = 0; end
    for (int s = 0; s < WIDTH; s++) begin e_cls[s] = 0; e_seq[s] = 0; end
    for (int p = 0; p < PASSES; p++) begin
      int drop, pick;
      int best;
      drop = -1; pick = -1; best = 0;
      for (int c = 0; c < NC; c++) begin
        bit ok;
        ok = took[c] < LOOK && took[c] < qs[c].size() && tot < WIDTH && used[c] < CAPS[c];
        if (ok && qq[c][took[c]] && drop < 0) drop = c;
        if (ok && (pick < 0 || int'(qs[c][took[c]]) < best)) begin
          pick = c; best = int'(qs[c][took[c]]);
        end
      end
      if (drop >= 0) took[drop]++;
      else if (pick >= 0) begin
        e_cls[tot] = pick; e_seq[tot] = best;
        took[pick]++; used[pick]++; tot++;
      end
    end
    e_sz = tot;
    for (int c = 0; c < NC; c++) begin
      e_pop[c] = took[c];
      e_stat[c] += used[c];
    end
  endtask

  task automatic check_regs();
    chk(int'(size) == e_sz, "R1 size", size, e_sz);
    for (int s = 0; s < WIDTH; s++) begin
      chk(slot_v[s] == (s < e_sz), "R1 slot valid", slot_v[s], s < e_sz);
      if (s < e_sz) begin
        chk(int'(slot_cls[s]) == e_cls[s], "R4 slot class", slot_cls[s], e_cls[s]);
        chk(int'(slot_seq[s]) == e_seq[s], "R4 slot seq", slot_seq[s], e_seq[s]);
      end
    end
    for (int c = 0; c < NC; c++)
      chk(longint'(stat[c]) == e_stat[c], "R9 stat", stat[c], e_stat[c]);
  endtask

  task automatic step();
    @(negedge clk);
    if (have_exp) check_regs();
    drive();
    #1;
    model();
    have_exp = 1;
    for (int c = 0; c < NC; c++) begin
      chk(int'(pop[c]) == e_pop[c], "R8 pop", pop[c], e_pop[c]);
      for (int k = 0; k < e_pop[c]; k++) begin
        void'(qs[c].pop_front());
        void'(qq[c].pop_front());
      end
    end
  endtask

  function automatic int pending();
    int n;
    n = 0;
    for (int c = 0; c < NC; c++) n += qs[c].size();
    return n;
  endfunction

  task automatic drain();
    int guard;
    guard = 0;
    while ((pending() > 0 || guard == 0) && guard < 50) begin
      step();
      guard++;
    end
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) e_stat[c] = 0;
    drive();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(slot_v == '0, "R10 slots", slot_v, 0);
    chk(size == '0, "R10 size", size, 0);
    for (int c = 0; c < NC; c++) chk(stat[c] == 0, "R10 stat", stat[c], 0);
    rst_n = 1'b1;
    step();

    tag = "R4";
    push(0, 30, 0); push(1, 10, 0); push(2, 20, 0);
    drain();

    tag = "R5";
    push(0, 50, 0); push(1, 50, 0); push(4, 50, 0); push(3, 40, 0);
    drain();

    tag = "R2";
    for (int i = 0; i < 4; i++) begin push(0, 200 + i, 0); push(2, 210 + i, 0); end
    for (int i = 0; i < 3; i++) push(3, 190 + i, 0);
    drain();

    tag = "R3";
    for (int i = 0; i < 6; i++) push(4, 300 + i, 0);
    push(2, 400, 0);
    drain();

    tag = "R6";
    push(0, 500, 1); push(0, 520, 0); push(1, 505, 1); push(1, 510, 0); push(4, 530, 0);
    drain();

    tag = "R7";
    for (int i = 0; i < 4; i++) begin push(0, 600 + i, 1); push(1, 610 + i, 1); end
    push(4, 620, 1); push(4, 621, 0); push(3, 630, 0);
    drain();

    tag = "R1";
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < 3; i++) push(c, 700 + 10 * i + c, 0);
    drain();

    seqctr = 1000;
    for (int cyc = 0; cyc < 400; cyc++) begin
      int n;
      n = $urandom_range(0, 3);
      for (int k = 0; k < n; k++) begin
        int c;
        c = $urandom_range(0, NC - 1);
        if (qs[c].size() < 10) begin
          seqctr += $urandom_range(1, 3);
          push(c, seqctr, $urandom_range(0, 4) == 0);
          if ($urandom_range(0, 7) == 0) begin
            int c2;
            c2 = (c + 1) % NC;
            if (qs[c2].size() < 10) push(c2, seqctr, 0);
          end
        end
      end
      step();
    end
    drain();

    done = 1;
    summary();
  end
endmodule